// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Master

This block configures an FPGA through its byte-wide slave-parallel port. It can also read the configuration memory back through the same pins. A single `start` pulse launches one operation, and `mode` selects which one. In load mode the block first pulses the device reset line, then waits for the device to report that it is ready. It frames the transfer with write-enable and chip-select and takes bytes from a ready/valid stream, placing each byte on the bus and strobing it with one configuration-clock pulse. When `chk_busy` is set, it keeps clocking while the device reports busy. After the last byte it releases the framing signals and keeps clocking until the device reports completion. In readback mode it asserts chip-select with write-enable low and issues `rd_count` clock pulses. It samples the bus after each rising edge and emits the byte on a valid-only stream.

All pin signals are logical levels: 1 means asserted. Any inversion the board needs sits outside the block. Every half period of the configuration clock lasts at least `HALF_CYC` system clocks. Each wait (device ready, busy stall, completion) is bounded by `TIMEOUT_CYC` system clocks. The `status` output gives the outcome: 0 idle, 1 running, 2 success, 4 ready timeout, 5 busy timeout, 6 completion timeout.

**States:**
- `S_IDLE`, `S_OK` and `S_FAIL` accept `start`.
- Load path:
  - `S_PROG` holds reset for `PROG_CYC` clocks.
  - `S_WAIT_RDY` leaves for `S_WR_ON` on ready, or for `S_FAIL` on timeout.
  - The path then runs `S_WR_ON` → `S_CS_ON` → `S_ARM` → `S_LD_GET`.
  - `S_LD_GET` moves to `S_LD_LOW` on a stream handshake, and `S_LD_LOW` moves to `S_LD_HIGH`.
  - `S_LD_HIGH` goes to `S_BSY_LOW` when checked busy is seen. Otherwise it goes to `S_REL_CS` after the last byte, or back to `S_LD_GET`.
  - `S_BSY_LOW` and `S_BSY_HIGH` loop until busy clears or the timeout fires.
  - The path continues with `S_REL_CS` → `S_REL_WR`, which goes to `S_OK` if completion is already seen and to `S_DN_LOW` otherwise.
  - `S_DN_LOW` and `S_DN_HIGH` loop until completion (to `S_OK`) or timeout (to `S_FAIL`).
- Readback path:
  - `S_RB_CS` goes to `S_RB_LOW`, or to `S_RB_END_CS` when the count is zero.
  - `S_RB_LOW` → `S_RB_HIGH`, which loops back to `S_RB_LOW` until the last byte and then goes to `S_RB_END_CS`.
  - The path ends `S_RB_END_CS` → `S_RB_END_LOW` → `S_RB_END_HIGH` → `S_OK`.

Top module: `pcfg_master`

## Requirements
- R1: After reset, `status` is 0, reset/chip-select/write-enable and the bus output enable are low, the configuration clock is high, and neither stream handshake is active.
- R2: A load first asserts `pin_prog` for exactly `PROG_CYC` clocks, with chip-select and write-enable low. It then waits for `pin_init`=1 and `pin_busy`=0 before framing.
- R3: In load, write-enable rises before chip-select. Chip-select falls while write-enable is still high, and write-enable falls after it. The bus output enable is high whenever both are asserted.
- R4: Stream bytes reach the bus in stream order, one per configuration-clock rising edge, and the bus holds steady across each such edge.
- R5: With `chk_busy`=1, while `pin_busy` is high after a byte, the block keeps issuing clock pulses with the same byte held and accepts no new byte until busy clears.
- R6: After the byte marked `s_last`, the block clocks with chip-select and write-enable low until `pin_done` is seen, issues no further pulse, and reports `status`=2.
- R7: A wait that exceeds `TIMEOUT_CYC` clocks ends with `status` 4 (ready), 5 (busy) or 6 (completion), with reset, chip-select and write-enable all released. The ready wait lasts exactly `TIMEOUT_CYC` clocks.
- R8: Readback keeps write-enable low and the bus undriven. It emits `rd_count` bytes on `m_valid`, each sampled after a rising edge, then releases chip-select and issues one more pulse, for `rd_count`+1 rising edges in total. A count of 0 emits nothing.
- R9: `start` is ignored while `status` is 1. The running operation continues unchanged, and `mode` and `rd_count` are only taken at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation when not running |
| mode | input | 1 | 0 load, 1 readback (taken at start) |
| chk_busy | input | 1 | Enable the per-byte busy stall loop |
| rd_count | input | CNT_W | Number of bytes to read back |
| s_data | input | DATA_W | Load stream byte |
| s_valid | input | 1 | Load stream byte valid |
| s_last | input | 1 | Marks the final load byte |
| s_ready | output | 1 | Load stream byte accepted this cycle |
| m_data | output | DATA_W | Readback byte |
| m_valid | output | 1 | Readback byte valid (one cycle) |
| pin_prog | output | 1 | Device reset request, asserted high |
| pin_cs | output | 1 | Chip-select, asserted high |
| pin_wr | output | 1 | Write-enable, asserted high |
| pin_cclk | output | 1 | Configuration clock |
| pin_d_out | output | DATA_W | Bus value driven during load |
| pin_d_oe | output | 1 | Bus output enable |
| pin_d_in | input | DATA_W | Bus value seen during readback |
| pin_init | input | 1 | Device ready for configuration |
| pin_busy | input | 1 | Device busy |
| pin_done | input | 1 | Device configuration complete |
| status | output | 3 | 0 idle, 1 running, 2 ok, 4/5/6 timeout reason |

## Verification
The assertions assume that a byte offered on the load stream stays put until accepted. They also assume that the device signals change only in response to the block's pins, never against the framing they check. The bench's device model meets these assumptions:
- Ready follows the release of reset.
- Busy is raised and lowered only on configuration-clock rising edges.
- Completion comes from counting post-frame rising edges.
- Readback bytes are presented on rising edges while chip-select is high and write-enable is low.

The stream driver changes data only on falling system-clock edges after a handshake.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PROG,
        S_WAIT_RDY,
        S_WR_ON,
        S_CS_ON,
        S_ARM,
        S_LD_GET,
        S_LD_LOW,
        S_LD_HIGH,
        S_BSY_LOW,
        S_BSY_HIGH,
        S_REL_CS,
        S_REL_WR,
        S_DN_LOW,
        S_DN_HIGH,
        S_RB_CS,
        S_RB_LOW,
        S_RB_HIGH,
        S_RB_END_CS,
        S_RB_END_LOW,
        S_RB_END_HIGH,
        S_OK,
        S_FAIL
    } pcfg_state_e;

    // wait groups: the shared timer restarts whenever the group changes
    typedef enum logic [2:0] {
        G_NONE,
        G_PROG,
        G_WAIT,
        G_BSY,
        G_DONE
    } pcfg_grp_e;

    localparam logic [2:0] ST_IDLE     = 3'd0;
    localparam logic [2:0] ST_RUN      = 3'd1;
    localparam logic [2:0] ST_OK       = 3'd2;
    localparam logic [2:0] ST_ERR_INIT = 3'd4;
    localparam logic [2:0] ST_ERR_BUSY = 3'd5;
    localparam logic [2:0] ST_ERR_DONE = 3'd6;

    function automatic pcfg_grp_e grp_of(pcfg_state_e s);
        case (s)
            S_PROG:               return G_PROG;
            S_WAIT_RDY:           return G_WAIT;
            S_BSY_LOW, S_BSY_HIGH: return G_BSY;
            S_DN_LOW, S_DN_HIGH:  return G_DONE;
            default:              return G_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pcfg_tick.sv
module pcfg_tick #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (HALF_CYC <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(HALF_CYC);
            localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == TOP)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick = (cnt_q == TOP);
        end
    endgenerate
endmodule

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pcfg_master.sv
module pcfg_master import pcfg_pkg::*; #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int HALF_CYC    = 4,
    parameter int PROG_CYC    = 100,
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic              chk_busy,
    input  logic [CNT_W-1:0]  rd_count,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    output logic              pin_prog,
    output logic              pin_cs,
    output logic              pin_wr,
    output logic              pin_cclk,
    output logic [DATA_W-1:0] pin_d_out,
    output logic              pin_d_oe,
    input  logic [DATA_W-1:0] pin_d_in,
    input  logic              pin_init,
    input  logic              pin_busy,
    input  logic              pin_done,
    output logic [2:0]        status
);
    localparam int TMAX = (TIMEOUT_CYC > PROG_CYC) ? TIMEOUT_CYC : PROG_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] TMO_END  = TW'(TIMEOUT_CYC - 1);
    localparam logic [TW-1:0] PROG_END = TW'(PROG_CYC - 1);

    pcfg_state_e state_q, state_d;
    logic              tick;
    logic [TW-1:0]     tcnt;
    logic              tmr_clr;
    logic              tmo_hit, prog_hit, launch;
    logic [DATA_W-1:0] dreg_q;
    logic              last_q;
    logic [CNT_W-1:0]  rem_q;
    logic [DATA_W-1:0] m_data_q;
    logic              m_valid_q;
    logic [2:0]        reason_q;

    pcfg_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pcfg_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tcnt)
    );

    assign tmr_clr  = (grp_of(state_d) != grp_of(state_q));
    assign tmo_hit  = (tcnt == TMO_END);
    assign prog_hit = (tcnt == PROG_END);
    assign launch   = start && (state_q inside {S_IDLE, S_OK, S_FAIL});

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_OK, S_FAIL:
                if (start) state_d = mode ? S_RB_CS : S_PROG;
            S_PROG:
                if (prog_hit) state_d = S_WAIT_RDY;
            S_WAIT_RDY:
                if (pin_init && !pin_busy) state_d = S_WR_ON;
                else if (tmo_hit)          state_d = S_FAIL;
            S_WR_ON:  if (tick) state_d = S_CS_ON;
            S_CS_ON:  if (tick) state_d = S_ARM;
            S_ARM:    if (tick) state_d = S_LD_GET;
            S_LD_GET: if (tick && s_valid) state_d = S_LD_LOW;
            S_LD_LOW: if (tick) state_d = S_LD_HIGH;
            S_LD_HIGH:
                if (tick) begin
                    if (chk_busy && pin_busy) state_d = S_BSY_LOW;
                    else if (last_q)          state_d = S_REL_CS;
                    else                      state_d = S_LD_GET;
                end
            S_BSY_LOW:
                if (tmo_hit)   state_d = S_FAIL;
                else if (tick) state_d = S_BSY_HIGH;
            S_BSY_HIGH:
                if (tmo_hit) state_d = S_FAIL;
                else if (tick) begin
                    if (pin_busy)    state_d = S_BSY_LOW;
                    else if (last_q) state_d = S_REL_CS;
                    else             state_d = S_LD_GET;
                end
            S_REL_CS: if (tick) state_d = S_REL_WR;
            S_REL_WR: if (tick) state_d = pin_done ? S_OK : S_DN_LOW;
            S_DN_LOW:
                if (tmo_hit)   state_d = S_FAIL;
                else if (tick) state_d = S_DN_HIGH;
            S_DN_HIGH:
                if (tmo_hit)   state_d = S_FAIL;
                else if (tick) state_d = pin_done ? S_OK : S_DN_LOW;
            S_RB_CS:
                if (tick) state_d = (rem_q == '0) ? S_RB_END_CS : S_RB_LOW;
            S_RB_LOW: if (tick) state_d = S_RB_HIGH;
            S_RB_HIGH:
                if (tick) state_d = (rem_q == CNT_W'(1)) ? S_RB_END_CS : S_RB_LOW;
            S_RB_END_CS:   if (tick) state_d = S_RB_END_LOW;
            S_RB_END_LOW:  if (tick) state_d = S_RB_END_HIGH;
            S_RB_END_HIGH: if (tick) state_d = S_OK;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dreg_q    <= '0;
            last_q    <= 1'b0;
            rem_q     <= '0;
            m_data_q  <= '0;
            m_valid_q <= 1'b0;
            reason_q  <= ST_ERR_INIT;
        end else begin
            m_valid_q <= 1'b0;
            if (s_ready && s_valid) begin
                dreg_q <= s_data;
                last_q <= s_last;
            end
            if (launch && mode)
                rem_q <= rd_count;
            if (state_q == S_RB_HIGH && tick) begin
                m_valid_q <= 1'b1;
                m_data_q  <= pin_d_in;
                rem_q     <= rem_q - CNT_W'(1);
            end
            if (state_d == S_FAIL && state_q != S_FAIL) begin
                case (grp_of(state_q))
                    G_WAIT:  reason_q <= ST_ERR_INIT;
                    G_BSY:   reason_q <= ST_ERR_BUSY;
                    default: reason_q <= ST_ERR_DONE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        pin_prog = (state_q == S_PROG);
        pin_wr   = state_q inside {S_WR_ON, S_CS_ON, S_ARM, S_LD_GET, S_LD_LOW,
                                   S_LD_HIGH, S_BSY_LOW, S_BSY_HIGH, S_REL_CS};
        pin_cs   = state_q inside {S_CS_ON, S_ARM, S_LD_GET, S_LD_LOW, S_LD_HIGH,
                                   S_BSY_LOW, S_BSY_HIGH,
                                   S_RB_CS, S_RB_LOW, S_RB_HIGH};
        pin_cclk = !(state_q inside {S_LD_LOW, S_BSY_LOW, S_DN_LOW,
                                     S_RB_LOW, S_RB_END_LOW});
        pin_d_oe = state_q inside {S_WR_ON, S_CS_ON, S_ARM, S_LD_GET, S_LD_LOW,
                                   S_LD_HIGH, S_BSY_LOW, S_BSY_HIGH, S_REL_CS};
        pin_d_out = dreg_q;
        s_ready   = (state_q == S_LD_GET) && tick;
        m_data    = m_data_q;
        m_valid   = m_valid_q;
        case (state_q)
            S_IDLE:  status = ST_IDLE;
            S_OK:    status = ST_OK;
            S_FAIL:  status = reason_q;
            default: status = ST_RUN;
        endcase
    end

endmodule

// File: rtl/pcfg_master_chk.sv
module pcfg_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin_prog,
    input logic              pin_cs,
    input logic              pin_wr,
    input logic              pin_cclk,
    input logic              pin_d_oe,
    input logic [DATA_W-1:0] pin_d_out,
    input logic              s_ready,
    input logic              m_valid,
    input logic [2:0]        status
);
    p_prog_unframed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_prog |-> (!pin_cs && !pin_wr));

    p_wr_leads_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin_cs) && pin_wr) |-> $past(pin_wr));

    p_bus_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cs && pin_wr) |-> pin_d_oe);

    p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pin_cclk) && pin_cs && pin_wr) |-> $stable(pin_d_out));

    p_take_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (pin_cs && pin_wr && pin_cclk));

    p_fail_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> (!pin_cs && !pin_wr && !pin_prog));

    p_readback_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cs && !pin_wr) |-> !pin_d_oe);

    p_rb_byte_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (!pin_wr && !pin_d_oe));
endmodule

bind pcfg_master pcfg_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_prog  (pin_prog),
    .pin_cs    (pin_cs),
    .pin_wr    (pin_wr),
    .pin_cclk  (pin_cclk),
    .pin_d_oe  (pin_d_oe),
    .pin_d_out (pin_d_out),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .status    (status)
);

// File: tb/pcfg_master_test.sv
module pcfg_master_test;
    localparam int HALF  = 2;
    localparam int PROGC = 8;
    localparam int TMO   = 400;
    localparam int CW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode = 1'b0, chk_busy = 1'b0;
    logic [CW-1:0] rd_count = '0;
    logic [7:0] s_data = '0;
    logic s_valid = 1'b0, s_last = 1'b0;
    logic s_ready, m_valid;
    logic [7:0] m_data;
    logic pin_prog, pin_cs, pin_wr, pin_cclk, pin_d_oe;
    logic [7:0] pin_d_out;
    logic [7:0] pin_d_in = '0;
    logic pin_init, pin_busy, pin_done;
    logic [2:0] status;

    int total = 0, bad = 0;
    bit finished = 0;

    // device model state
    logic [7:0] exp_ld[$];
    logic [7:0] exp_rb[$];
    logic [7:0] rb_src[$];
    bit init_en = 1, mdl_busy = 0, rb_mode = 0, ord_chk = 1;
    int bsy_at = -1, bsy_len = 0, bsy_left = 0, bsy_edges = 0, cap_idx = 0;
    int dn_need = 0, dn_edges = 0, rb_idx = 0, rb_edges = 0;
    int prog_cyc = 0, wait_cyc = 0, ord_bad = 0, rb_bad = 0;

    assign pin_init = init_en & ~pin_prog;
    assign pin_busy = mdl_busy;
    assign pin_done = (dn_edges >= dn_need);

    pcfg_master #(.DATA_W(8), .CNT_W(CW), .HALF_CYC(HALF),
                  .PROG_CYC(PROGC), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chk_busy(chk_busy),
        .rd_count(rd_count), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid),
        .pin_prog(pin_prog), .pin_cs(pin_cs), .pin_wr(pin_wr), .pin_cclk(pin_cclk),
        .pin_d_out(pin_d_out), .pin_d_oe(pin_d_oe), .pin_d_in(pin_d_in),
        .pin_init(pin_init), .pin_busy(pin_busy), .pin_done(pin_done),
        .status(status)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // device model: reacts to configuration-clock rising edges
    always @(posedge pin_cclk) begin
        if (pin_cs && pin_wr) begin
            if (mdl_busy) begin
                bsy_edges++;
                bsy_left--;
                if (bsy_left <= 0) mdl_busy = 0;
            end else begin
                logic [7:0] e;
                if (exp_ld.size() == 0) begin
                    check(0, "R4 unexpected byte", int'(pin_d_out), -1);
                end else begin
                    e = exp_ld.pop_front();
                    check(pin_d_out == e, "R4 byte order", int'(pin_d_out), int'(e));
                end
                if (cap_idx == bsy_at) begin
                    mdl_busy = 1;
                    bsy_left = bsy_len;
                end
                cap_idx++;
            end
        end else if (pin_cs && !pin_wr) begin
            if (rb_idx < rb_src.size()) pin_d_in = rb_src[rb_idx];
            rb_idx++;
        end
        if (!pin_cs && !pin_wr && !rb_mode) dn_edges++;
        if (rb_mode) rb_edges++;
    end

    always @(posedge pin_cs) if (ord_chk && !rb_mode && !pin_wr) ord_bad++;
    always @(negedge pin_cs) if (ord_chk && !rb_mode && !pin_wr) ord_bad++;
    always @(negedge pin_wr) if (ord_chk && pin_cs) ord_bad++;

    // monitor: counts, bus direction and readback scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (pin_prog) prog_cyc++;
            if (status == 3'd1 && !pin_prog && !pin_wr && !rb_mode && cap_idx == 0)
                wait_cyc++;
            if (rb_mode && (pin_wr || pin_d_oe)) rb_bad++;
            if (!rb_mode && pin_cs && pin_wr && !pin_d_oe) ord_bad++;
            if (m_valid) begin
                logic [7:0] e;
                if (exp_rb.size() == 0) begin
                    check(0, "R8 unexpected readback byte", int'(m_data), -1);
                end else begin
                    e = exp_rb.pop_front();
                    check(m_data == e, "R8 readback byte", int'(m_data), int'(e));
                end
            end
        end
    end

    task automatic model_clear();
        bsy_at = -1; bsy_len = 0; bsy_left = 0; mdl_busy = 0; bsy_edges = 0;
        cap_idx = 0; dn_edges = 0; prog_cyc = 0; wait_cyc = 0; ord_bad = 0;
        rb_bad = 0; rb_edges = 0; rb_idx = 0; ord_chk = 1; init_en = 1;
        rb_src.delete(); exp_ld.delete(); exp_rb.delete();
    endtask

    task automatic kick(input bit md, input int cnt);
        @(negedge clk);
        mode = md; rd_count = CW'(cnt); start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_end(output int code);
        code = -1;
        for (int i = 0; i < 20000; i++) begin
            if (status != 3'd1) begin
                code = int'(status);
                break;
            end
            @(negedge clk);
        end
        if (code == -1) check(0, "watchdog operation hung", -1, 0);
    endtask

    // driver: pushes expected bytes, then offers them on the stream
    task automatic send(input int n, input int base, input int gap, input int inj_at);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'(base + i * 29);
            exp_ld.push_back(v);
            repeat (gap) @(negedge clk);
            s_data = v; s_valid = 1; s_last = (i == n - 1);
            while (1'b1) begin
                if (status != 3'd1) begin
                    s_valid = 0; s_last = 0;
                    return;
                end
                if (s_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
            s_valid = 0; s_last = 0;
            if (i == inj_at) begin
                mode = 1; rd_count = CW'(5); start = 1;
                @(negedge clk);
                start = 0; mode = 0;
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int code;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(status == 3'd0, "R1 status idle", int'(status), 0);
        check(!pin_prog && !pin_cs && !pin_wr && !pin_d_oe, "R1 pins released",
              int'({pin_prog, pin_cs, pin_wr, pin_d_oe}), 0);
        check(pin_cclk == 1'b1, "R1 cclk high", int'(pin_cclk), 1);
        check(!s_ready && !m_valid, "R1 streams quiet", int'({s_ready, m_valid}), 0);

        // plain load, R2 R3 R4 R6
        model_clear(); dn_need = 3; chk_busy = 0;
        kick(0, 0);
        send(5, 8'h11, 0, -1);
        wait_end(code);
        check(code == 2, "R6 load success", code, 2);
        check(exp_ld.size() == 0, "R4 all bytes delivered", exp_ld.size(), 0);
        check(prog_cyc == PROGC, "R2 reset pulse width", prog_cyc, PROGC);
        check(ord_bad == 0, "R3 framing order", ord_bad, 0);
        check(dn_edges == 3, "R6 pulses until done", dn_edges, 3);

        // gapped stream with busy stall, R5
        model_clear(); dn_need = 2; chk_busy = 1; bsy_at = 2; bsy_len = 3;
        kick(0, 0);
        send(6, 8'hA0, 3, -1);
        wait_end(code);
        check(code == 2, "R5 load with stall success", code, 2);
        check(exp_ld.size() == 0, "R5 bytes after stall", exp_ld.size(), 0);
        check(bsy_edges == 3, "R5 stall pulses", bsy_edges, 3);
        check(ord_bad == 0, "R3 framing order with stall", ord_bad, 0);

        // ready timeout, R7
        model_clear(); init_en = 0; ord_chk = 0;
        kick(0, 0);
        wait_end(code);
        check(code == 4, "R7 ready timeout code", code, 4);
        check(wait_cyc == TMO, "R7 ready wait length", wait_cyc, TMO);
        check(!pin_prog && !pin_cs && !pin_wr, "R7 released after ready timeout",
              int'({pin_prog, pin_cs, pin_wr}), 0);

        // busy timeout, R7
        model_clear(); ord_chk = 0; chk_busy = 1; bsy_at = 0; bsy_len = 1000000; dn_need = 1;
        kick(0, 0);
        send(3, 8'h40, 0, -1);
        wait_end(code);
        check(code == 5, "R7 busy timeout code", code, 5);
        check(!pin_cs && !pin_wr, "R7 released after busy timeout",
              int'({pin_cs, pin_wr}), 0);

        // completion timeout, R7
        model_clear(); ord_chk = 0; chk_busy = 0; dn_need = 1000000;
        kick(0, 0);
        send(2, 8'h70, 1, -1);
        wait_end(code);
        check(code == 6, "R7 done timeout code", code, 6);

        // readback of four bytes, R8
        model_clear(); rb_mode = 1; dn_need = 0;
        for (int i = 0; i < 4; i++) begin
            rb_src.push_back(8'(i * 37 + 5));
            exp_rb.push_back(8'(i * 37 + 5));
        end
        kick(1, 4);
        wait_end(code);
        check(code == 2, "R8 readback success", code, 2);
        check(exp_rb.size() == 0, "R8 all bytes read", exp_rb.size(), 0);
        check(rb_edges == 5, "R8 rising edges", rb_edges, 5);
        check(rb_bad == 0, "R8 bus undriven", rb_bad, 0);

        // readback of zero bytes, R8
        model_clear(); rb_mode = 1;
        kick(1, 0);
        wait_end(code);
        check(code == 2, "R8 empty readback success", code, 2);
        check(rb_edges == 1, "R8 empty readback edges", rb_edges, 1);
        rb_mode = 0;

        // start while running is ignored, R9
        model_clear(); dn_need = 2; chk_busy = 0;
        kick(0, 0);
        send(4, 8'h23, 0, 1);
        wait_end(code);
        check(code == 2, "R9 load unaffected by start", code, 2);
        check(exp_ld.size() == 0, "R9 bytes unaffected", exp_ld.size(), 0);
        check(prog_cyc == PROGC, "R9 no second reset pulse", prog_cyc, PROGC);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule